// File: doc/BRIEF.md
# Capability-aware leaf PTE permission checker

This block decides whether an access may use a valid leaf page-table entry. The first stage is the standard permission rules of the page-based virtual memory scheme, which look at the PTE's U, R, W and X bits, the current privilege and the MXR and SUM controls. Two capability rules sit on top of them. A store that carries a capability is gated by a capability-write bit in the PTE's extension field. A load that fetches a capability receives a three-way action: keep the tag, clear the tag, or trap.

The load action can depend on a per-page generation bit. That bit is compared against one of two global generation bits. The PTE's own U bit chooses which global bit is used, and the privilege of the access plays no part in the choice. The global pair comes from the supervisor control register when supervisor mode exists, and from the machine control register otherwise. The computed action is merged with the load-capability state gathered earlier in the walk.

The checker is purely combinational and sits inside the translation pipe. A parameter selects a variant for short-PTE formats that have no extension field. In that variant the capability bits take fixed defaults.

Top module: `cap_pte_perm`

## Requirements
- R1: For user privilege (`priv`=00), a read needs U=1 and either R=1 or (X=1 with `mxr`=1). A write needs U=1 and W=1, and an execute needs U=1 and X=1. A failing check gives `ok`=0 with `fail_code`=0, the no-permission code.
- R2: For supervisor privilege (`priv`=01), a read or write of a page with U=1 is allowed only when `sum`=1, and an execute of a page with U=1 is never allowed. Otherwise a read needs R=1 or (X=1 with `mxr`=1), a write needs W=1 and an execute needs X=1.
- R3: When `priv`[1]=1 (machine level), the result is `ok`=0 and `internal_err`=1.
- R4: A failure of the base rules reports `fail_code`=0 even when a capability rule would also fail, and `lc_out` then equals `lc_in`.
- R5: Access kinds are encoded on `acc_kind` as 00 execute, 01 read, 10 write and 11 read-write. When the base rules pass, a write or read-write with `wr_cap`=1 fails with `fail_code`=1 (capability error) if the capability-write bit (extension bit 9) is 0, and passes if it is 1. When `wr_cap`=0 this bit has no effect.
- R6: Load actions are encoded 00 OK, 01 CLEAR and 10 TRAP. For a passing read or read-write with `rd_cap`=1, the triple (capability-read bit 8, read-trap bit 6, page-generation bit 5) selects the action: (0,0,0) gives CLEAR, (0,1,0) gives TRAP, (1,0,0) gives OK, and (1,1,g) gives OK when g equals the selected global bit and TRAP otherwise.
- R7: The global generation bit is taken from the page's U bit: bit 1 of the chosen pair when U=1, bit 0 when U=0. The pair is `s_gen` when `has_smode`=1 and `m_gen` when `has_smode`=0.
- R8: The computed action merges with `lc_in` as follows. An OK action leaves `lc_in` as it is. A CLEAR action turns OK into CLEAR and leaves TRAP as TRAP. A TRAP action always produces TRAP.
- R9: When there is no capability read leg, or when the access fails, `lc_out` equals `lc_in`.
- R10: The reserved triples (0,x,1) and (1,0,1) drive `internal_err`=1 for any access. A capability read of such a page computes the TRAP action.
- R11: With `EXT_PRESENT`=0 the extension input is ignored. The block then behaves as if the capability-write and capability-read bits were 1 and the read-trap and page-generation bits were 0.
- R12: A read-write access must pass both the read rule and the write rule of its privilege.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_kind | input | 2 | Access kind: 00 execute, 01 read, 10 write, 11 read-write |
| rd_cap | input | 1 | The read leg fetches a capability |
| wr_cap | input | 1 | The write leg stores a capability |
| priv | input | 2 | Privilege: 00 user, 01 supervisor, 1x machine |
| mxr | input | 1 | Executable pages are also readable |
| sum | input | 1 | Supervisor may access user pages |
| pte_u | input | 1 | PTE user-page bit |
| pte_r | input | 1 | PTE read bit |
| pte_w | input | 1 | PTE write bit |
| pte_x | input | 1 | PTE execute bit |
| pte_ext | input | EXT_W | PTE extension field |
| s_gen | input | 2 | Supervisor-register generation bits: [1] user pages, [0] system pages |
| m_gen | input | 2 | Machine-register generation bits, same layout |
| has_smode | input | 1 | Supervisor mode is implemented |
| lc_in | input | 2 | Incoming load-capability action |
| ok | output | 1 | Access permitted |
| fail_code | output | 1 | On failure: 0 no permission, 1 capability error |
| lc_out | output | 2 | Resulting load-capability action |
| internal_err | output | 1 | Machine-level check or reserved extension triple |

## Verification
The bench builds two copies from the same stimulus. The first uses the default 10-bit extension field with the capability bits at positions 9, 8, 6 and 5, which brings the full load-action table, the generation compare and the reserved triples within reach. The second sets `EXT_PRESENT`=0, so the fixed-default variant can be compared against the same accesses. Together they cover base-rule priority over capability errors, the choice of global bit by page U bit rather than by privilege, and the merge with each incoming action.

// File: rtl/cap_pte_pkg.sv
package cap_pte_pkg;

   localparam int LC_W = 2;

   localparam logic [LC_W-1:0] LC_OK    = 2'b00;
   localparam logic [LC_W-1:0] LC_CLEAR = 2'b01;
   localparam logic [LC_W-1:0] LC_TRAP  = 2'b10;

   localparam logic [1:0] ACC_EXEC  = 2'b00;
   localparam logic [1:0] ACC_READ  = 2'b01;
   localparam logic [1:0] ACC_WRITE = 2'b10;
   localparam logic [1:0] ACC_RDWR  = 2'b11;

   localparam logic [1:0] PRIV_USER = 2'b00;
   localparam logic [1:0] PRIV_SUP  = 2'b01;

   // Merge of an accumulated action with a newly computed one.
   // Any value with the upper bit set counts as TRAP.
   function automatic logic [LC_W-1:0] lc_merge(input logic [LC_W-1:0] acc,
                                                 input logic [LC_W-1:0] add);
      logic [LC_W-1:0] res;
      if (acc[1] || add[1])
         res = LC_TRAP;
      else if (acc[0] || add[0])
         res = LC_CLEAR;
      else
         res = LC_OK;
      return res;
   endfunction

endpackage

// File: rtl/cpc_base_perm.sv
module cpc_base_perm (
   input  logic [1:0] acc_kind,
   input  logic [1:0] priv,
   input  logic       mxr,
   input  logic       sum,
   input  logic       pte_u,
   input  logic       pte_r,
   input  logic       pte_w,
   input  logic       pte_x,
   output logic       base_ok,
   output logic       priv_bad
);
   import cap_pte_pkg::*;

   logic is_exec;
   logic rd_leg;
   logic wr_leg;
   logic rd_bits_ok;
   logic rw_bits_ok;

   always_comb begin
      is_exec    = (acc_kind == ACC_EXEC);
      rd_leg     = acc_kind[0];
      wr_leg     = acc_kind[1];
      rd_bits_ok = pte_r | (pte_x & mxr);
      rw_bits_ok = (!rd_leg | rd_bits_ok) & (!wr_leg | pte_w);
      priv_bad   = priv[1];
      base_ok    = 1'b0;
      if (!priv[1]) begin
         if (priv == PRIV_USER) begin
            if (is_exec) base_ok = pte_u & pte_x;
            else         base_ok = pte_u & rw_bits_ok;
         end else begin
            if (is_exec) base_ok = !pte_u & pte_x;
            else         base_ok = (!pte_u | sum) & rw_bits_ok;
         end
      end
   end

endmodule

// File: rtl/cpc_ext_decode.sv
module cpc_ext_decode #(
   parameter int EXT_W       = 10,
   parameter int CW_POS      = 9,
   parameter int CR_POS      = 8,
   parameter int CRT_POS     = 6,
   parameter int CRG_POS     = 5,
   parameter bit EXT_PRESENT = 1'b1
) (
   input  logic [EXT_W-1:0] pte_ext,
   output logic             cap_wr_en,
   output logic             cap_rd_en,
   output logic             cap_rd_trap,
   output logic             cap_rd_gen
);

   generate
      if (EXT_PRESENT) begin : g_ext
         assign cap_wr_en   = pte_ext[CW_POS];
         assign cap_rd_en   = pte_ext[CR_POS];
         assign cap_rd_trap = pte_ext[CRT_POS];
         assign cap_rd_gen  = pte_ext[CRG_POS];
      end else begin : g_fixed
         logic unused_ext;
         assign unused_ext  = ^pte_ext;
         assign cap_wr_en   = 1'b1;
         assign cap_rd_en   = 1'b1;
         assign cap_rd_trap = 1'b0;
         assign cap_rd_gen  = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/cpc_load_action.sv
module cpc_load_action (
   input  logic       cap_rd_en,
   input  logic       cap_rd_trap,
   input  logic       cap_rd_gen,
   input  logic       pte_u,
   input  logic [1:0] s_gen,
   input  logic [1:0] m_gen,
   input  logic       has_smode,
   output logic [1:0] act,
   output logic       reserved
);
   import cap_pte_pkg::*;

   logic [1:0] gen_pair;
   logic       glob_bit;

   always_comb begin
      gen_pair = has_smode ? s_gen : m_gen;
      glob_bit = pte_u ? gen_pair[1] : gen_pair[0];
      reserved = 1'b0;
      unique case ({cap_rd_en, cap_rd_trap, cap_rd_gen})
         3'b000: act = LC_CLEAR;
         3'b010: act = LC_TRAP;
         3'b100: act = LC_OK;
         3'b110,
         3'b111: act = (cap_rd_gen == glob_bit) ? LC_OK : LC_TRAP;
         default: begin
            act      = LC_TRAP;
            reserved = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/cap_pte_perm.sv
module cap_pte_perm #(
   parameter int EXT_W       = 10,
   parameter int CW_POS      = 9,
   parameter int CR_POS      = 8,
   parameter int CRT_POS     = 6,
   parameter int CRG_POS     = 5,
   parameter bit EXT_PRESENT = 1'b1
) (
   input  logic [1:0]       acc_kind,
   input  logic             rd_cap,
   input  logic             wr_cap,
   input  logic [1:0]       priv,
   input  logic             mxr,
   input  logic             sum,
   input  logic             pte_u,
   input  logic             pte_r,
   input  logic             pte_w,
   input  logic             pte_x,
   input  logic [EXT_W-1:0] pte_ext,
   input  logic [1:0]       s_gen,
   input  logic [1:0]       m_gen,
   input  logic             has_smode,
   input  logic [1:0]       lc_in,
   output logic             ok,
   output logic             fail_code,
   output logic [1:0]       lc_out,
   output logic             internal_err
);
   import cap_pte_pkg::*;

   localparam int MAX_POS = (CW_POS > CR_POS ? CW_POS : CR_POS) >
                            (CRT_POS > CRG_POS ? CRT_POS : CRG_POS) ?
                            (CW_POS > CR_POS ? CW_POS : CR_POS) :
                            (CRT_POS > CRG_POS ? CRT_POS : CRG_POS);

   generate
      if (MAX_POS >= EXT_W) begin : g_bad_width
         $error("extension bit position beyond EXT_W");
      end
      if (CW_POS == CR_POS || CW_POS == CRT_POS || CW_POS == CRG_POS ||
          CR_POS == CRT_POS || CR_POS == CRG_POS || CRT_POS == CRG_POS) begin : g_bad_pos
         $error("extension bit positions must be distinct");
      end
   endgenerate

   logic       base_ok;
   logic       priv_bad;
   logic       cap_wr_en;
   logic       cap_rd_en;
   logic       cap_rd_trap;
   logic       cap_rd_gen;
   logic [1:0] load_act;
   logic       ext_reserved;
   logic       store_block;
   logic       cap_read_leg;

   cpc_base_perm u_base (
      .acc_kind (acc_kind),
      .priv     (priv),
      .mxr      (mxr),
      .sum      (sum),
      .pte_u    (pte_u),
      .pte_r    (pte_r),
      .pte_w    (pte_w),
      .pte_x    (pte_x),
      .base_ok  (base_ok),
      .priv_bad (priv_bad)
   );

   cpc_ext_decode #(
      .EXT_W       (EXT_W),
      .CW_POS      (CW_POS),
      .CR_POS      (CR_POS),
      .CRT_POS     (CRT_POS),
      .CRG_POS     (CRG_POS),
      .EXT_PRESENT (EXT_PRESENT)
   ) u_dec (
      .pte_ext     (pte_ext),
      .cap_wr_en   (cap_wr_en),
      .cap_rd_en   (cap_rd_en),
      .cap_rd_trap (cap_rd_trap),
      .cap_rd_gen  (cap_rd_gen)
   );

   cpc_load_action u_load (
      .cap_rd_en   (cap_rd_en),
      .cap_rd_trap (cap_rd_trap),
      .cap_rd_gen  (cap_rd_gen),
      .pte_u       (pte_u),
      .s_gen       (s_gen),
      .m_gen       (m_gen),
      .has_smode   (has_smode),
      .act         (load_act),
      .reserved    (ext_reserved)
   );

   always_comb begin
      store_block  = acc_kind[1] & wr_cap & !cap_wr_en;
      cap_read_leg = acc_kind[0] & rd_cap;
      ok           = !priv_bad & base_ok & !store_block;
      fail_code    = !priv_bad & base_ok & store_block;
      internal_err = priv_bad | ext_reserved;
      if (ok && cap_read_leg)
         lc_out = lc_merge(lc_in, load_act);
      else
         lc_out = lc_in;
   end

endmodule

// File: rtl/cpc_checker.sv
module cpc_checker #(
   parameter int EXT_W       = 10,
   parameter int CW_POS      = 9,
   parameter bit EXT_PRESENT = 1'b1
) (
   input logic [1:0]       acc_kind,
   input logic             rd_cap,
   input logic             wr_cap,
   input logic [1:0]       priv,
   input logic             mxr,
   input logic             sum,
   input logic             pte_u,
   input logic             pte_r,
   input logic             pte_w,
   input logic             pte_x,
   input logic [EXT_W-1:0] pte_ext,
   input logic [1:0]       s_gen,
   input logic [1:0]       m_gen,
   input logic             has_smode,
   input logic [1:0]       lc_in,
   input logic             ok,
   input logic             fail_code,
   input logic [1:0]       lc_out,
   input logic             internal_err
);

   logic known;
   logic cw_bit;

   assign known  = !$isunknown({acc_kind, rd_cap, wr_cap, priv, mxr, sum, pte_u, pte_r,
                                pte_w, pte_x, pte_ext, s_gen, m_gen, has_smode, lc_in,
                                ok, fail_code, lc_out, internal_err});
   assign cw_bit = EXT_PRESENT ? pte_ext[CW_POS] : 1'b1;

   always_comb begin
      if (known) begin
         a_r3_machine_level: assert (!priv[1] || (!ok && internal_err))
            else $error("R3 machine-level check not flagged");
         a_r5_cap_err_cause: assert (!(!ok && fail_code) || (acc_kind[1] && wr_cap && !cw_bit))
            else $error("R5 capability error without blocked capability store");
         a_r1_user_page: assert (!(ok && priv == 2'b00) || pte_u)
            else $error("R1 user access allowed on system page");
         a_r2_sup_exec: assert (!(ok && priv == 2'b01 && acc_kind == 2'b00) || !pte_u)
            else $error("R2 supervisor execute on user page");
         a_r8_trap_sticky: assert (lc_in != 2'b10 || lc_out == 2'b10)
            else $error("R8 incoming TRAP lost");
         a_r9_passthrough: assert ((ok && acc_kind[0] && rd_cap) || lc_out == lc_in)
            else $error("R9 action changed without capability read");
         a_r4_fail_exclusive: assert (!(ok && fail_code))
            else $error("R4 failure code raised on success");
      end
   end

endmodule

bind cap_pte_perm cpc_checker #(
   .EXT_W       (EXT_W),
   .CW_POS      (CW_POS),
   .EXT_PRESENT (EXT_PRESENT)
) u_chk (.*);

// File: tb/tb_cap_pte_perm.sv
module tb_cap_pte_perm;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 5000;

   localparam logic [9:0] E_CW  = 10'h200;
   localparam logic [9:0] E_CR  = 10'h100;
   localparam logic [9:0] E_CRT = 10'h040;
   localparam logic [9:0] E_CRG = 10'h020;

   logic       clk = 1'b0;
   logic [1:0] acc_kind = 2'b00;
   logic       rd_cap = 1'b0, wr_cap = 1'b0;
   logic [1:0] priv = 2'b00;
   logic       mxr = 1'b0, sum = 1'b0;
   logic       pte_u = 1'b0, pte_r = 1'b0, pte_w = 1'b0, pte_x = 1'b0;
   logic [9:0] pte_ext = '0;
   logic [1:0] s_gen = 2'b00, m_gen = 2'b00;
   logic       has_smode = 1'b1;
   logic [1:0] lc_in = 2'b00;

   logic       ok, fail_code, internal_err;
   logic [1:0] lc_out;
   logic       f_ok, f_fail_code, f_internal_err;
   logic [1:0] f_lc_out;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cap_pte_perm dut (
      .acc_kind(acc_kind), .rd_cap(rd_cap), .wr_cap(wr_cap), .priv(priv),
      .mxr(mxr), .sum(sum), .pte_u(pte_u), .pte_r(pte_r), .pte_w(pte_w),
      .pte_x(pte_x), .pte_ext(pte_ext), .s_gen(s_gen), .m_gen(m_gen),
      .has_smode(has_smode), .lc_in(lc_in), .ok(ok), .fail_code(fail_code),
      .lc_out(lc_out), .internal_err(internal_err)
   );

   cap_pte_perm #(.EXT_PRESENT(1'b0)) dut_flat (
      .acc_kind(acc_kind), .rd_cap(rd_cap), .wr_cap(wr_cap), .priv(priv),
      .mxr(mxr), .sum(sum), .pte_u(pte_u), .pte_r(pte_r), .pte_w(pte_w),
      .pte_x(pte_x), .pte_ext(pte_ext), .s_gen(s_gen), .m_gen(m_gen),
      .has_smode(has_smode), .lc_in(lc_in), .ok(f_ok), .fail_code(f_fail_code),
      .lc_out(f_lc_out), .internal_err(f_internal_err)
   );

   task automatic drive(input logic [1:0] k, input logic rc, input logic wc,
                        input logic [1:0] p, input logic [3:0] urwx,
                        input logic [9:0] ext, input logic [1:0] lci);
      @(posedge clk);
      acc_kind = k; rd_cap = rc; wr_cap = wc; priv = p;
      {pte_u, pte_r, pte_w, pte_x} = urwx;
      pte_ext = ext; lc_in = lci;
      @(negedge clk);
   endtask

   task automatic expect_main(input string req, input logic e_ok, input logic e_code,
                              input logic [1:0] e_lc, input logic e_ierr);
      n_checks++;
      if (ok !== e_ok || fail_code !== e_code || lc_out !== e_lc || internal_err !== e_ierr) begin
         n_fails++;
         $display("FAIL %s: got ok=%b code=%b lc=%b ierr=%b, expected ok=%b code=%b lc=%b ierr=%b",
                  req, ok, fail_code, lc_out, internal_err, e_ok, e_code, e_lc, e_ierr);
      end
   endtask

   task automatic expect_flat(input string req, input logic e_ok, input logic e_code,
                              input logic [1:0] e_lc, input logic e_ierr);
      n_checks++;
      if (f_ok !== e_ok || f_fail_code !== e_code || f_lc_out !== e_lc || f_internal_err !== e_ierr) begin
         n_fails++;
         $display("FAIL %s (flat): got ok=%b code=%b lc=%b ierr=%b, expected ok=%b code=%b lc=%b ierr=%b",
                  req, f_ok, f_fail_code, f_lc_out, f_internal_err, e_ok, e_code, e_lc, e_ierr);
      end
   endtask

   // urwx = {U,R,W,X}
   task automatic t_idle();
      @(negedge clk);
      expect_main("R1 idle user exec of system page", 1'b0, 1'b0, 2'b00, 1'b0);
   endtask

   task automatic t_user_base();
      mxr = 1'b0;
      drive(2'b01, 0, 0, 2'b00, 4'b1100, E_CW | E_CR, 2'b00);
      expect_main("R1 user read U=1 R=1", 1, 0, 2'b00, 0);
      drive(2'b01, 0, 0, 2'b00, 4'b1001, E_CW | E_CR, 2'b00);
      expect_main("R1 user read X only, mxr=0", 0, 0, 2'b00, 0);
      mxr = 1'b1;
      drive(2'b01, 0, 0, 2'b00, 4'b1001, E_CW | E_CR, 2'b00);
      expect_main("R1 user read X only, mxr=1", 1, 0, 2'b00, 0);
      mxr = 1'b0;
      drive(2'b10, 0, 0, 2'b00, 4'b1100, E_CW | E_CR, 2'b00);
      expect_main("R1 user write W=0", 0, 0, 2'b00, 0);
      drive(2'b01, 0, 0, 2'b00, 4'b0100, E_CW | E_CR, 2'b00);
      expect_main("R1 user read U=0", 0, 0, 2'b00, 0);
   endtask

   task automatic t_sup_base();
      sum = 1'b0;
      drive(2'b01, 0, 0, 2'b01, 4'b1100, E_CW | E_CR, 2'b00);
      expect_main("R2 sup read user page sum=0", 0, 0, 2'b00, 0);
      sum = 1'b1;
      drive(2'b01, 0, 0, 2'b01, 4'b1100, E_CW | E_CR, 2'b00);
      expect_main("R2 sup read user page sum=1", 1, 0, 2'b00, 0);
      drive(2'b00, 0, 0, 2'b01, 4'b1001, E_CW | E_CR, 2'b00);
      expect_main("R2 sup exec user page sum=1", 0, 0, 2'b00, 0);
      sum = 1'b0;
      drive(2'b00, 0, 0, 2'b01, 4'b0001, E_CW | E_CR, 2'b00);
      expect_main("R2 sup exec system page", 1, 0, 2'b00, 0);
   endtask

   task automatic t_machine();
      drive(2'b01, 0, 0, 2'b11, 4'b1111, E_CW | E_CR, 2'b01);
      expect_main("R3 machine level", 0, 0, 2'b01, 1);
   endtask

   task automatic t_priority();
      drive(2'b11, 1, 1, 2'b00, 4'b1100, 10'h000, 2'b01);
      expect_main("R4 base failure over capability error", 0, 0, 2'b01, 0);
   endtask

   task automatic t_store_gate();
      drive(2'b10, 0, 1, 2'b00, 4'b1010, E_CR, 2'b00);
      expect_main("R5 cap store CW=0", 0, 1, 2'b00, 0);
      drive(2'b10, 0, 1, 2'b00, 4'b1010, E_CW | E_CR, 2'b00);
      expect_main("R5 cap store CW=1", 1, 0, 2'b00, 0);
      drive(2'b10, 0, 0, 2'b00, 4'b1010, E_CR, 2'b00);
      expect_main("R5 data store CW=0", 1, 0, 2'b00, 0);
      drive(2'b11, 1, 0, 2'b00, 4'b1110, E_CR, 2'b00);
      expect_main("R5 rdwr cap read, data write, CW=0", 1, 0, 2'b00, 0);
   endtask

   task automatic t_load_table();
      has_smode = 1'b1; s_gen = 2'b00;
      drive(2'b01, 1, 0, 2'b00, 4'b1100, 10'h000, 2'b00);
      expect_main("R6 triple 000 -> CLEAR", 1, 0, 2'b01, 0);
      drive(2'b01, 1, 0, 2'b00, 4'b1100, E_CRT, 2'b00);
      expect_main("R6 triple 010 -> TRAP", 1, 0, 2'b10, 0);
      drive(2'b01, 1, 0, 2'b00, 4'b1100, E_CR, 2'b00);
      expect_main("R6 triple 100 -> OK", 1, 0, 2'b00, 0);
      drive(2'b01, 1, 0, 2'b00, 4'b1100, E_CR | E_CRT, 2'b00);
      expect_main("R6 triple 110 gen match -> OK", 1, 0, 2'b00, 0);
      s_gen = 2'b10;
      drive(2'b01, 1, 0, 2'b00, 4'b1100, E_CR | E_CRT, 2'b00);
      expect_main("R6 triple 110 gen mismatch -> TRAP", 1, 0, 2'b10, 0);
   endtask

   task automatic t_gen_select();
      has_smode = 1'b1; s_gen = 2'b01;
      drive(2'b01, 1, 0, 2'b01, 4'b0100, E_CR | E_CRT | E_CRG, 2'b00);
      expect_main("R7 U=0 page uses system bit (match)", 1, 0, 2'b00, 0);
      s_gen = 2'b10;
      drive(2'b01, 1, 0, 2'b01, 4'b0100, E_CR | E_CRT | E_CRG, 2'b00);
      expect_main("R7 U=0 page ignores user bit", 1, 0, 2'b10, 0);
      sum = 1'b1; s_gen = 2'b01;
      drive(2'b01, 1, 0, 2'b01, 4'b1100, E_CR | E_CRT | E_CRG, 2'b00);
      expect_main("R7 sup priv, U=1 page uses user bit", 1, 0, 2'b10, 0);
      sum = 1'b0;
      has_smode = 1'b0; m_gen = 2'b01; s_gen = 2'b10;
      drive(2'b01, 1, 0, 2'b01, 4'b0100, E_CR | E_CRT | E_CRG, 2'b00);
      expect_main("R7 no sup mode uses machine pair", 1, 0, 2'b00, 0);
      has_smode = 1'b1; s_gen = 2'b00; m_gen = 2'b00;
   endtask

   task automatic t_join();
      drive(2'b01, 1, 0, 2'b00, 4'b1100, E_CR, 2'b01);
      expect_main("R8 CLEAR in, OK action", 1, 0, 2'b01, 0);
      drive(2'b01, 1, 0, 2'b00, 4'b1100, 10'h000, 2'b10);
      expect_main("R8 TRAP in, CLEAR action", 1, 0, 2'b10, 0);
      drive(2'b01, 1, 0, 2'b00, 4'b1100, 10'h000, 2'b00);
      expect_main("R8 OK in, CLEAR action", 1, 0, 2'b01, 0);
      drive(2'b11, 1, 0, 2'b00, 4'b1110, E_CRT, 2'b01);
      expect_main("R8 CLEAR in, TRAP action", 1, 0, 2'b10, 0);
   endtask

   task automatic t_passthrough();
      drive(2'b01, 0, 0, 2'b00, 4'b1100, E_CRT, 2'b01);
      expect_main("R9 data read keeps lc_in", 1, 0, 2'b01, 0);
      drive(2'b10, 1, 0, 2'b00, 4'b1010, E_CRT, 2'b00);
      expect_main("R9 pure write keeps lc_in", 1, 0, 2'b00, 0);
      drive(2'b01, 1, 0, 2'b00, 4'b0100, 10'h000, 2'b00);
      expect_main("R9 failed cap read keeps lc_in", 0, 0, 2'b00, 0);
   endtask

   task automatic t_reserved();
      drive(2'b00, 0, 0, 2'b00, 4'b1001, E_CRG, 2'b00);
      expect_main("R10 reserved 001 on execute", 1, 0, 2'b00, 1);
      drive(2'b01, 1, 0, 2'b00, 4'b1100, E_CR | E_CRG, 2'b00);
      expect_main("R10 reserved 101 on cap read", 1, 0, 2'b10, 1);
      drive(2'b01, 1, 0, 2'b00, 4'b1100, E_CRT | E_CRG, 2'b01);
      expect_main("R10 reserved 011 on cap read", 1, 0, 2'b10, 1);
   endtask

   task automatic t_flat();
      drive(2'b10, 0, 1, 2'b00, 4'b1010, 10'h000, 2'b00);
      expect_flat("R11 cap store, ext ignored", 1, 0, 2'b00, 0);
      drive(2'b01, 1, 0, 2'b00, 4'b1100, E_CRG, 2'b00);
      expect_flat("R11 cap read, ext ignored", 1, 0, 2'b00, 0);
      expect_main("R10 same pattern on full variant", 1, 0, 2'b10, 1);
   endtask

   task automatic t_rdwr();
      drive(2'b11, 0, 0, 2'b00, 4'b1100, E_CW | E_CR, 2'b00);
      expect_main("R12 rdwr needs W", 0, 0, 2'b00, 0);
      drive(2'b11, 0, 0, 2'b00, 4'b1010, E_CW | E_CR, 2'b00);
      expect_main("R12 rdwr needs R", 0, 0, 2'b00, 0);
      drive(2'b11, 0, 0, 2'b00, 4'b1110, E_CW | E_CR, 2'b00);
      expect_main("R12 rdwr with R and W", 1, 0, 2'b00, 0);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      t_idle();
      t_user_base();
      t_sup_base();
      t_machine();
      t_priority();
      t_store_gate();
      t_load_table();
      t_gen_select();
      t_join();
      t_passthrough();
      t_reserved();
      t_flat();
      t_rdwr();
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: got no completion, expected completion within %0d cycles", WATCHDOG);
         finish_run();
      end
   end

endmodule